// File: doc/BRIEF.md
# Grouped Vectored Interrupt Controller

This block gathers a large set of interrupt sources and turns them into one request line toward a processor. Sources are packed eight to a byte-wide group. Source number n lives in group n/8 at bit n%8. Each group has four byte registers on a simple register bus: pending status, enable, trigger mode and polarity.

Each raw input first passes through a two-stage synchronizer. The block then applies either a level test or a single-edge test to it and latches the result as pending status. Software clears a pending bit by writing a 1 to it. A read-only vector register reports the lowest-numbered source that is both pending and enabled, offset by 0x10. Software reads the vector to find the source it must service.

With the default parameters there are 29 groups, which gives 232 sources. Groups 0 to 2 sit at byte addresses 0x04 to 0x0F. The vector register takes address 0x10. Groups 3 and above start at 0x14.

Top module: `grp_vec_intc`

## Requirements
- R1: Group g's registers are at byte address 4*(g+k) plus an offset, where k is 1 for groups 0 to 2 and 2 for higher groups. The offsets are +0 status, +1 enable, +2 mode and +3 polarity. Enable, mode and polarity read back the last value written to them.
- R2: Address 0x10 reads the winning source number plus 0x10. It reads 0x00 when no source is both pending and enabled. Writes to 0x10 are ignored.
- R3: Writing a 1 to a status bit clears it. Writing a 0 to a status bit leaves it unchanged.
- R4: With mode bit 0 (level), a status bit sets on every cycle the input is active. Active means high when polarity is 0 and low when polarity is 1. Because of this, a clear does not take effect while the input stays active.
- R5: With mode bit 1 (edge), a status bit sets once on an inactive-to-active transition of the synchronized input. Polarity 0 selects rising edges and polarity 1 selects falling edges. The opposite edge and a steady input set nothing.
- R6: A source whose enable bit is 0 still latches status, but it drives neither the request nor the vector.
- R7: irq_o is high exactly when some source has both its status bit and its enable bit set.
- R8: After reset, all status, enable, mode and polarity bits are 0, irq_o is low and the vector reads 0x00.
- R9: Addresses that are neither a group register nor the vector read 0x00, and writes to them change no state. This includes 0x00 to 0x03, the hole at 0x11 to 0x13 and everything past the last group.
- R10: A change on a source input shows in its status bit after the third rising clock edge, and not after the second.
- R11: Priority is fixed, and the lowest-numbered pending and enabled source wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_GROUPS*GRP_W (232) | Raw interrupt source inputs |
| addr_i | input | ADDR_W (8) | Register byte address |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | GRP_W (8) | Write data |
| rdata_o | output | GRP_W (8) | Read data, combinational from addr_i |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A register write takes effect at the rising edge on which we_i is sampled. Read data is combinational from addr_i and state, so the bench samples it half a cycle after setting the address. A source change reaches its status bit at the third rising edge. irq_o and the vector then follow in the same cycle. The bench therefore reads status at the falling edge after both the second and the third rising edge, expecting the old and then the new value. All edge and level checks wait at least three full cycles before sampling.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // Register offset inside a group's four-byte bank.
  typedef enum logic [1:0] {
    FLD_STAT = 2'd0,
    FLD_EN   = 2'd1,
    FLD_MODE = 2'd2,
    FLD_POL  = 2'd3
  } fld_e;

  // Groups below this index sit before the vector hole.
  localparam int LOW_GROUPS = 3;

  // Word address (byte address / 4) of group g's bank.
  function automatic int group_word(input int g);
    return g + ((g < LOW_GROUPS) ? 1 : 2);
  endfunction
endpackage

// File: rtl/intc_group.sv
module intc_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic         wr_stat_i,
  input  logic         wr_en_i,
  input  logic         wr_mode_i,
  input  logic         wr_pol_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] mode_o,
  output logic [W-1:0] pol_o
);
  logic [W-1:0] s1_q, s2_q, prv_q;
  logic [W-1:0] stat_q, en_q, mode_q, pol_q;
  logic [W-1:0] stat_d, en_d, mode_d, pol_d;
  logic [W-1:0] act_now, act_old, hit, clr;

  // Trigger detection on the synchronized input.
  always_comb begin
    act_now = s2_q ^ pol_q;
    act_old = prv_q ^ pol_q;
    hit     = (~mode_q & act_now) | (mode_q & act_now & ~act_old);
    clr     = wr_stat_i ? wdata_i : '0;
    stat_d  = (stat_q & ~clr) | hit;
    en_d    = wr_en_i   ? wdata_i : en_q;
    mode_d  = wr_mode_i ? wdata_i : mode_q;
    pol_d   = wr_pol_i  ? wdata_i : pol_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prv_q  <= '0;
      stat_q <= '0;
      en_q   <= '0;
      mode_q <= '0;
      pol_q  <= '0;
    end else begin
      s1_q   <= src_i;
      s2_q   <= s1_q;
      prv_q  <= s2_q;
      stat_q <= stat_d;
      en_q   <= en_d;
      mode_q <= mode_d;
      pol_q  <= pol_d;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign mode_o = mode_q;
  assign pol_o  = pol_q;

  // R3: written ones clear unless a trigger lands on the same edge
  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat_i |=> ((stat_q & $past(wdata_i & ~hit)) == '0));
  // R3: written zeros keep pending bits
  a_r3_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat_i |=> ((stat_q & $past(stat_q & ~wdata_i)) == $past(stat_q & ~wdata_i)));
  // R5: no status bit rises without a detected trigger
  a_r5_set_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q) & ~$past(hit)) == '0));
  // R4: an active level-mode input always leaves its bit set
  a_r4_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & $past(~mode_q & act_now)) == $past(~mode_q & act_now)));
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int N   = 232,
  parameter int VW  = 8,
  parameter int OFS = 16
) (
  input  logic [N-1:0]  pend_i,
  output logic [VW-1:0] vec_o,
  output logic          any_o
);
  // Scan from the top so the lowest set index is written last.
  always_comb begin
    vec_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        vec_o = VW'(i + OFS);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/grp_vec_intc.sv
module grp_vec_intc #(
  parameter int NUM_GROUPS = 29,
  parameter int GRP_W      = 8,
  parameter int ADDR_W     = 8,
  parameter int VEC_ADDR   = 16,
  parameter int VEC_OFS    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_GROUPS*GRP_W-1:0] src_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        we_i,
  input  logic [GRP_W-1:0]            wdata_i,
  output logic [GRP_W-1:0]            rdata_o,
  output logic                        irq_o
);
  import intc_pkg::*;

  localparam int NUM_SRC = NUM_GROUPS * GRP_W;
  localparam int WORD_W  = ADDR_W - 2;

  logic rst_meta_q, rst_sync_q;
  logic [WORD_W-1:0] word;
  fld_e              fld;
  logic [NUM_SRC-1:0] pend;
  logic [GRP_W-1:0]  grp_rd [NUM_GROUPS];
  logic [GRP_W-1:0]  vec;
  logic              any;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign word = addr_i[ADDR_W-1:2];
  assign fld  = fld_e'(addr_i[1:0]);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic sel;
    logic [GRP_W-1:0] st, en, md, pl;

    assign sel = (int'(word) == group_word(g));

    intc_group #(.W(GRP_W)) u_grp (
      .clk       (clk),
      .rst_n     (rst_sync_q),
      .src_i     (src_i[g*GRP_W +: GRP_W]),
      .wr_stat_i (we_i && sel && (fld == FLD_STAT)),
      .wr_en_i   (we_i && sel && (fld == FLD_EN)),
      .wr_mode_i (we_i && sel && (fld == FLD_MODE)),
      .wr_pol_i  (we_i && sel && (fld == FLD_POL)),
      .wdata_i   (wdata_i),
      .stat_o    (st),
      .en_o      (en),
      .mode_o    (md),
      .pol_o     (pl)
    );

    assign pend[g*GRP_W +: GRP_W] = st & en;

    always_comb begin
      grp_rd[g] = '0;
      if (sel) begin
        unique case (fld)
          FLD_STAT: grp_rd[g] = st;
          FLD_EN:   grp_rd[g] = en;
          FLD_MODE: grp_rd[g] = md;
          FLD_POL:  grp_rd[g] = pl;
        endcase
      end
    end
  end

  intc_prio #(.N(NUM_SRC), .VW(GRP_W), .OFS(VEC_OFS)) u_prio (
    .pend_i (pend),
    .vec_o  (vec),
    .any_o  (any)
  );

  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < NUM_GROUPS; g++) rdata_o = rdata_o | grp_rd[g];
    if (int'(addr_i) == VEC_ADDR) rdata_o = vec;
  end

  assign irq_o = |pend;

  // R7: request and vector agree
  a_r7_irq_vec: assert property (@(posedge clk) disable iff (!rst_sync_q)
    irq_o == (vec != '0));
  // R11: winner is pending and no lower source is
  a_r11_lowest_wins: assert property (@(posedge clk) disable iff (!rst_sync_q)
    any |-> (pend[int'(vec) - VEC_OFS] &&
             ((pend << (NUM_SRC - (int'(vec) - VEC_OFS))) == '0)));
endmodule

// File: tb/grp_vec_intc_tb.sv
module grp_vec_intc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NG  = 29;
  localparam int NS  = NG * 8;
  localparam int VEC = 16;

  logic          clk;
  logic          rst_n;
  logic [NS-1:0] src;
  logic [7:0]    addr;
  logic          we;
  logic [7:0]    wdata;
  logic [7:0]    rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;

  grp_vec_intc dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int base(input int g);
    return 4 * (g + ((g < 3) ? 1 : 2));
  endfunction

  function automatic bit mapped(input int a);
    int w;
    w = a / 4;
    return (a == VEC) || (w >= 1 && w <= 3) || (w >= 5 && w < NG + 2);
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = 8'(a); wdata = 8'(d); we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    addr = 8'(a);
    #1;
    d = int'(rdata);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d;
    int s, g, b;
    src = '0; addr = '0; we = 1'b0; wdata = '0;
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R8: reset state
    for (int gg = 0; gg < NG; gg++)
      for (int f = 0; f < 4; f++) begin
        rd(base(gg) + f, d); check("R8 reg", d, 0);
      end
    rd(VEC, d); check("R8 vector", d, 0);
    check("R8 irq", int'(irq), 0);

    // R1: enable/mode/polarity read back in every group
    for (int gg = 0; gg < NG; gg++)
      for (int f = 1; f < 4; f++) wr(base(gg) + f, (gg * 7 + f * 31 + 1) & 8'hFF);
    for (int gg = 0; gg < NG; gg++)
      for (int f = 1; f < 4; f++) begin
        rd(base(gg) + f, d); check("R1 readback", d, (gg * 7 + f * 31 + 1) & 8'hFF);
      end
    for (int gg = 0; gg < NG; gg++)
      for (int f = 1; f < 4; f++) wr(base(gg) + f, 0);
    cyc(4);
    for (int gg = 0; gg < NG; gg++) wr(base(gg), 8'hFF);
    // R3: ones clear every status bit
    for (int gg = 0; gg < NG; gg++) begin
      rd(base(gg), d); check("R3 clear all", d, 0);
    end
    check("R7 irq idle", int'(irq), 0);

    // R9: unused addresses read zero and ignore writes; R2 vector read-only
    for (int a = 0; a < 256; a++)
      if (!mapped(a) || a == VEC) wr(a, 8'hFF);
    for (int a = 0; a < 256; a++)
      if (!mapped(a)) begin
        rd(a, d); check("R9 unused read", d, 0);
      end
    for (int gg = 0; gg < NG; gg++)
      for (int f = 0; f < 4; f++) begin
        rd(base(gg) + f, d); check("R9 no side effect", d, 0);
      end
    rd(VEC, d); check("R2 vector ignores write", d, 0);

    // R10/R4: level high on source 43 (group 5 bit 3)
    s = 43; g = s / 8; b = s % 8;
    wr(base(g) + 1, 1 << b);
    @(negedge clk); src[s] = 1'b1;
    cyc(2);
    rd(base(g), d); check("R10 not after 2 edges", d, 0);
    cyc(1);
    rd(base(g), d); check("R10 set after 3 edges", d, 1 << b);
    rd(VEC, d); check("R2 vector value", d, s + VEC);
    check("R7 irq on", int'(irq), 1);
    wr(base(g), 1 << b);
    rd(base(g), d); check("R4 level re-sets after clear", d, 1 << b);
    src[s] = 1'b0;
    cyc(4);
    wr(base(g), 8'h00);
    rd(base(g), d); check("R3 zero write keeps", d, 1 << b);
    wr(base(g), 1 << b);
    rd(base(g), d); check("R3 cleared", d, 0);
    check("R7 irq off", int'(irq), 0);

    // R4: active-low level
    wr(base(g) + 3, 1 << b);
    cyc(2);
    rd(base(g), d); check("R4 low level sets", d, 1 << b);
    src[s] = 1'b1;
    cyc(4);
    wr(base(g), 1 << b);
    cyc(2);
    rd(base(g), d); check("R4 inactive high stays clear", d, 0);
    wr(base(g) + 3, 0); wr(base(g) + 1, 0);
    src[s] = 1'b0;
    cyc(4); wr(base(g), 8'hFF);

    // R5: rising edge on source 100 (group 12 bit 4)
    s = 100; g = s / 8; b = s % 8;
    wr(base(g) + 2, 1 << b);
    wr(base(g) + 1, 1 << b);
    @(negedge clk); src[s] = 1'b1;
    cyc(3);
    rd(base(g), d); check("R5 rising sets", d, 1 << b);
    wr(base(g), 1 << b);
    cyc(5);
    rd(base(g), d); check("R5 steady high no reset", d, 0);
    src[s] = 1'b0;
    cyc(5);
    rd(base(g), d); check("R5 falling ignored in rising mode", d, 0);
    // falling-edge mode
    wr(base(g) + 3, 1 << b);
    cyc(4); wr(base(g), 8'hFF);
    src[s] = 1'b1;
    cyc(5);
    rd(base(g), d); check("R5 rising ignored in falling mode", d, 0);
    src[s] = 1'b0;
    cyc(4);
    rd(base(g), d); check("R5 falling sets", d, 1 << b);
    rd(VEC, d); check("R2 edge vector", d, s + VEC);
    wr(base(g), 1 << b);
    cyc(4);
    rd(base(g), d); check("R5 steady low no reset", d, 0);
    wr(base(g) + 1, 0); wr(base(g) + 2, 0); wr(base(g) + 3, 0);
    cyc(4); wr(base(g), 8'hFF);

    // R6: masked source latches but stays silent
    s = 200; g = s / 8; b = s % 8;
    src[s] = 1'b1;
    cyc(4);
    rd(base(g), d); check("R6 status latches", d, 1 << b);
    check("R6 irq masked", int'(irq), 0);
    rd(VEC, d); check("R6 vector masked", d, 0);
    wr(base(g) + 1, 1 << b);
    check("R6 irq after enable", int'(irq), 1);
    wr(base(g) + 1, 0);
    src[s] = 1'b0;
    cyc(4); wr(base(g), 8'hFF);

    // R11: every source active, peel enables off from the bottom
    src = '1;
    for (int gg = 0; gg < NG; gg++) wr(base(gg) + 1, 8'hFF);
    cyc(4);
    for (int n = 0; n < NS; n++) begin
      rd(VEC, d); check("R11 lowest wins", d, n + VEC);
      check("R7 irq with pending", int'(irq), 1);
      wr(base(n / 8) + 1, (8'hFF << (n % 8 + 1)) & 8'hFF);
    end
    rd(VEC, d); check("R2 vector empty", d, 0);
    check("R7 irq all masked", int'(irq), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule